// File: doc/BRIEF.md
# Register-Offset Vector Load Address Generator

This block takes a 32-bit register-offset vector/floating-point load word with a valid strobe and works out the effective memory address. It pulls the base, index and destination register numbers out of the word. It reads the base and index values through two combinational read ports into a 64-bit general register file. It extends and optionally scales the index, adds the result to the base and registers the outcome.

Alongside the address it reports the destination register number and the transfer size as a log2 byte count. It also reports two rejection flags. One marks a word that is not this instruction class at all. The other marks a word of the right class whose field values are undefined. The memory access, privilege checks and vector register writeback happen elsewhere.

Top module: `vldag_top`

## Requirements
- R1: If any fixed bit differs from its required value, `out_nomatch` is 1, `out_undef` is 0 and `out_addr` is 0. The required values are: bits 29:27 = 111, bit 26 = 1, bits 25:24 = 00, bit 22 = 1, bit 21 = 1, bits 11:10 = 10.
- R2: The scale is {bit 23, bits 31:30} and is reported on `out_scale`. A matched word with scale above 4 sets `out_undef` and forces `out_addr` to 0.
- R3: A matched word whose option field (bits 15:13) has its middle bit (bit 14) at 0 sets `out_undef` and forces `out_addr` to 0.
- R4: Option 010 uses the index's low 32 bits, zero-extended to 64.
- R5: Option 110 uses the index's low 32 bits, sign-extended from bit 31.
- R6: Options 011 and 111 use the full 64-bit index unchanged.
- R7: When bit 12 is 1, the extended index is shifted left by the scale. When bit 12 is 0, it is not shifted.
- R8: Base register number 31 (bits 9:5) takes the stack pointer input `sp_value`. Index register number 31 (bits 20:16) reads as zero. Other numbers read the register file.
- R9: The address is base plus the shifted index, modulo 2^64.
- R10: The outputs update on the clock edge that samples `in_valid` high, with `out_dest` = bits 4:0. `out_valid` is high for exactly the cycles that follow a strobe. Without a strobe, the other outputs hold their values.
- R11: While `rst` is high, every output is 0, including `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word strobe |
| in_word | input | 32 | Instruction word |
| sp_value | input | 64 | Stack pointer value |
| rf_base_sel | output | 5 | Register file read address, base |
| rf_base_data | input | 64 | Register file read data, base |
| rf_index_sel | output | 5 | Register file read address, index |
| rf_index_data | input | 64 | Register file read data, index |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Effective address |
| out_scale | output | 3 | log2 of transfer size in bytes |
| out_dest | output | 5 | Destination vector register number |
| out_undef | output | 1 | Undefined encoding |
| out_nomatch | output | 1 | Word is not this instruction class |

## Verification
The assertions check several properties on every cycle:
- the one-cycle strobe-to-valid relation and the holding of outputs between strobes;
- that the two rejection flags are never both high;
- that a rejected word carries a zero address;
- the upper-half shape of the extended index for each option.

Only the bench scenarios can show that the sum itself is right. They walk every size, opcode, option and shift combination against a reference model, using odd registers whose low 32 bits are negative. Separate cases cover the stack pointer and zero-register substitutions, wrap past 2^64, and strobes during reset.

// File: rtl/vldag_pkg.sv
package vldag_pkg;
  localparam int XLEN      = 64;
  localparam int IW        = 32;
  localparam int REGW      = 5;
  localparam int SCW       = 3;
  localparam int OPTW      = 3;
  localparam int MAX_SCALE = 4;
  localparam logic [REGW-1:0] SPECIAL_REG = '1;

  typedef struct packed {
    logic [REGW-1:0] rt;
    logic [REGW-1:0] rn;
    logic [REGW-1:0] rm;
    logic [SCW-1:0]  scale;
    logic [OPTW-1:0] opt;
    logic            sh_en;
    logic            nomatch;
    logic            undef;
  } dec_t;
endpackage

// File: rtl/vldag_decode.sv
module vldag_decode
  import vldag_pkg::*;
(
  input  logic [IW-1:0] word,
  output dec_t          dec
);
  logic fixed_ok;

  always_comb begin
    fixed_ok = (word[29:27] == 3'b111) && word[26] && (word[25:24] == 2'b00)
             && word[22] && word[21] && (word[11:10] == 2'b10);
    dec.rt      = word[4:0];
    dec.rn      = word[9:5];
    dec.rm      = word[20:16];
    dec.opt     = word[15:13];
    dec.sh_en   = word[12];
    dec.scale   = {word[23], word[31:30]};
    dec.nomatch = !fixed_ok;
    dec.undef   = fixed_ok && ((dec.scale > SCW'(MAX_SCALE)) || !dec.opt[1]);
  end
endmodule

// File: rtl/vldag_index_ext.sv
module vldag_index_ext #(
  parameter int XW  = 64,
  parameter int OW  = 3,
  parameter int SW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [XW-1:0] raw,
  input  logic [OW-1:0] opt,
  input  logic          sh_en,
  input  logic [SW-1:0] scale,
  output logic [XW-1:0] ext,
  output logic [XW-1:0] shifted
);
  localparam int HALF = XW / 2;
  logic [SW-1:0] shamt;

  always_comb begin
    if (opt[0]) ext = raw;
    else if (opt[2]) ext = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
    else ext = {{HALF{1'b0}}, raw[HALF-1:0]};
    shamt   = sh_en ? scale : '0;
    shifted = ext << shamt;
  end

  // R4: zero extension leaves an empty upper half
  a_r4_zero_upper: assert property (@(posedge clk) disable iff (rst)
    (opt == 3'b010) |-> (ext[XW-1:HALF] == '0));
  // R5: sign extension replicates bit HALF-1 of the source
  a_r5_sign_upper: assert property (@(posedge clk) disable iff (rst)
    (opt == 3'b110) |-> (ext[XW-1:HALF] == {HALF{raw[HALF-1]}}));
  // R6: full-width options pass the index through
  a_r6_full_pass: assert property (@(posedge clk) disable iff (rst)
    opt[0] |-> (ext == raw));
  // R7: without scaling the shifted value equals the extended one
  a_r7_no_shift: assert property (@(posedge clk) disable iff (rst)
    !sh_en |-> (shifted == ext));
endmodule

// File: rtl/vldag_top.sv
module vldag_top
  import vldag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IW-1:0]    in_word,
  input  logic [XLEN-1:0]  sp_value,
  output logic [REGW-1:0]  rf_base_sel,
  input  logic [XLEN-1:0]  rf_base_data,
  output logic [REGW-1:0]  rf_index_sel,
  input  logic [XLEN-1:0]  rf_index_data,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_addr,
  output logic [SCW-1:0]   out_scale,
  output logic [REGW-1:0]  out_dest,
  output logic             out_undef,
  output logic             out_nomatch
);
  dec_t            dec;
  logic [XLEN-1:0] base_val, index_raw, index_ext, index_sh, sum;

  vldag_decode u_dec (.word(in_word), .dec(dec));

  assign rf_base_sel  = dec.rn;
  assign rf_index_sel = dec.rm;

  always_comb begin
    base_val  = (dec.rn == SPECIAL_REG) ? sp_value : rf_base_data;
    index_raw = (dec.rm == SPECIAL_REG) ? '0 : rf_index_data;
  end

  vldag_index_ext #(.XW(XLEN), .OW(OPTW), .SW(SCW)) u_ext (
    .clk(clk), .rst(rst), .raw(index_raw), .opt(dec.opt),
    .sh_en(dec.sh_en), .scale(dec.scale), .ext(index_ext), .shifted(index_sh)
  );

  assign sum = base_val + index_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_scale   <= '0;
      out_dest    <= '0;
      out_undef   <= 1'b0;
      out_nomatch <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr    <= (dec.nomatch || dec.undef) ? '0 : sum;
        out_scale   <= dec.scale;
        out_dest    <= dec.rt;
        out_undef   <= dec.undef;
        out_nomatch <= dec.nomatch;
      end
    end
  end

  // R10: a strobe yields valid on the next cycle and only then
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r10_hold_addr: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_addr));
  // R1: the two rejection flags are exclusive
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_undef && out_nomatch));
  // R1 / R2 / R3: rejected words carry no address
  a_r2_reject_zero: assert property (@(posedge clk) disable iff (rst)
    (out_undef || out_nomatch) |-> (out_addr == '0));
endmodule

// File: tb/vldag_top_test.sv
module vldag_top_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_word;
  logic [63:0] sp_value;
  logic [4:0]  rf_base_sel, rf_index_sel;
  logic [63:0] rf_base_data, rf_index_data;
  logic        out_valid, out_undef, out_nomatch;
  logic [63:0] out_addr;
  logic [2:0]  out_scale;
  logic [4:0]  out_dest;
  logic [63:0] regs [32];
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  assign rf_base_data  = regs[rf_base_sel];
  assign rf_index_data = regs[rf_index_sel];

  vldag_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .sp_value(sp_value),
    .rf_base_sel(rf_base_sel), .rf_base_data(rf_base_data),
    .rf_index_sel(rf_index_sel), .rf_index_data(rf_index_data),
    .out_valid(out_valid), .out_addr(out_addr), .out_scale(out_scale),
    .out_dest(out_dest), .out_undef(out_undef), .out_nomatch(out_nomatch)
  );

  function automatic logic [31:0] enc(input logic [1:0] sz, input logic op1,
      input logic [2:0] opt, input logic s, input logic [4:0] rm,
      input logic [4:0] rn, input logic [4:0] rt);
    return {sz, 3'b111, 1'b1, 2'b00, op1, 1'b1, 1'b1, rm, opt, s, 2'b10, rn, rt};
  endfunction

  // {expected nomatch, expected undef, word}
  localparam logic [33:0] VEC [9] = '{
    {2'b00, enc(2'd2, 1'b0, 3'b011, 1'b1, 5'd4, 5'd3, 5'd7)},
    {2'b00, enc(2'd0, 1'b1, 3'b111, 1'b0, 5'd5, 5'd3, 5'd9)},
    {2'b01, enc(2'd1, 1'b1, 3'b010, 1'b0, 5'd5, 5'd3, 5'd1)},
    {2'b01, enc(2'd3, 1'b1, 3'b110, 1'b1, 5'd5, 5'd3, 5'd2)},
    {2'b01, enc(2'd2, 1'b0, 3'b001, 1'b0, 5'd5, 5'd3, 5'd3)},
    {2'b01, enc(2'd0, 1'b0, 3'b100, 1'b1, 5'd5, 5'd3, 5'd4)},
    {2'b10, enc(2'd2, 1'b0, 3'b011, 1'b0, 5'd5, 5'd3, 5'd5) ^ 32'h0000_0400},
    {2'b10, enc(2'd2, 1'b0, 3'b011, 1'b0, 5'd5, 5'd3, 5'd6) ^ 32'h0040_0000},
    {2'b10, enc(2'd2, 1'b0, 3'b011, 1'b0, 5'd5, 5'd3, 5'd8) ^ 32'h0200_0000}
  };

  task automatic model(input logic [31:0] w, output logic nm, output logic un,
                       output logic [63:0] addr);
    logic [2:0]  sc;
    logic [63:0] idx, b;
    nm = (w[29:27] != 3'b111) || !w[26] || (w[25:24] != 2'b00) || !w[22] || !w[21]
         || (w[11:10] != 2'b10);
    sc = {w[23], w[31:30]};
    un = !nm && ((sc > 3'd4) || (w[14] == 1'b0));
    idx = (w[20:16] == 5'd31) ? 64'd0 : regs[w[20:16]];
    case (w[15:13])
      3'b010:  idx = {32'd0, idx[31:0]};
      3'b110:  idx = {{32{idx[31]}}, idx[31:0]};
      default: idx = idx;
    endcase
    if (w[12]) idx = idx << sc;
    b = (w[9:5] == 5'd31) ? sp_value : regs[w[9:5]];
    addr = (nm || un) ? 64'd0 : b + idx;
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_word(input string tag, input logic [31:0] w);
    logic nm, un;
    logic [63:0] a;
    model(w, nm, un, a);
    apply(w);
    checks++;
    if (!out_valid || out_nomatch !== nm || out_undef !== un || out_addr !== a
        || out_dest !== w[4:0] || out_scale !== {w[23], w[31:30]}) begin
      errors++;
      $display("FAIL %s word=%h actual v=%b nm=%b un=%b addr=%h dest=%0d sc=%0d expected v=1 nm=%b un=%b addr=%h dest=%0d sc=%0d",
               tag, w, out_valid, out_nomatch, out_undef, out_addr, out_dest, out_scale,
               nm, un, a, w[4:0], {w[23], w[31:30]});
    end
  endtask

  task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++)
      regs[i] = {32'h0000_1000 + i, (i % 2 == 1) ? 32'h8000_0010 + i : 32'h0000_0100 + i};
    sp_value = 64'hFFFF_FFFF_FFFF_FF00;
    rst = 1'b1;
    in_valid = 1'b0;
    in_word = '0;
    repeat (3) @(negedge clk);
    // R11: outputs cleared in reset, even with a strobe present
    in_valid = 1'b1;
    in_word = enc(2'd2, 1'b0, 3'b011, 1'b0, 5'd4, 5'd3, 5'd7);
    @(negedge clk);
    check_val("R11 reset outputs",
              {out_valid, out_undef, out_nomatch, out_dest, out_scale, out_addr[48:0]}, '0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // Table of flag expectations, addresses from the model
    foreach (VEC[k]) begin
      check_word("R1 R2 R3 table", VEC[k][31:0]);
      check_val("R1 R2 R3 table flags", {62'd0, out_nomatch, out_undef},
                {62'd0, VEC[k][33:32]});
    end

    // Sweep every size/opc/option/S with a negative-low index (reg 5)
    for (int sz = 0; sz < 4; sz++)
      for (int op = 0; op < 2; op++)
        for (int opt = 0; opt < 8; opt++)
          for (int s = 0; s < 2; s++) begin
            logic [31:0] w;
            string tag;
            w = enc(sz[1:0], op[0], opt[2:0], s[0], 5'd5, 5'd3, 5'(opt + 8));
            if ({op[0], sz[1:0]} > 3'd4) tag = "R2 sweep";
            else if (opt[1] == 1'b0) tag = "R3 sweep";
            else if (opt == 2) tag = "R4 R7 sweep";
            else if (opt == 6) tag = "R5 R7 sweep";
            else tag = "R6 R7 sweep";
            check_word(tag, w);
          end

    // R4 hand value: zero-extend low 32 of reg 5 (0x80000015), no shift, base reg 4
    check_word("R4 hand", enc(2'd0, 1'b0, 3'b010, 1'b0, 5'd5, 5'd4, 5'd1));
    check_val("R4 hand addr", out_addr, 64'h0000_1004_0000_0104 + 64'h0000_0000_8000_0015);
    // R5 hand value: sign-extended, S=1 scale 3
    check_word("R5 hand", enc(2'd3, 1'b0, 3'b110, 1'b1, 5'd5, 5'd4, 5'd1));
    check_val("R5 hand addr", out_addr, 64'h0000_1004_0000_0104 + (64'hFFFF_FFFF_8000_0015 << 3));
    // R7 hand value: scale 4 shift with full index
    check_word("R7 hand", enc(2'd0, 1'b1, 3'b011, 1'b1, 5'd2, 5'd4, 5'd2));
    check_val("R7 hand addr", out_addr, 64'h0000_1004_0000_0104 + 64'h0001_0020_0000_1020);
    // R8: index 31 reads zero, base 31 uses stack pointer
    check_word("R8 zero index", enc(2'd2, 1'b0, 3'b011, 1'b1, 5'd31, 5'd6, 5'd3));
    check_val("R8 zero index addr", out_addr, regs[6]);
    check_word("R8 sp base", enc(2'd2, 1'b0, 3'b111, 1'b0, 5'd31, 5'd31, 5'd3));
    check_val("R8 sp base addr", out_addr, 64'hFFFF_FFFF_FFFF_FF00);
    // R9: wrap past 2^64
    check_word("R9 wrap", enc(2'd0, 1'b0, 3'b011, 1'b0, 5'd2, 5'd31, 5'd0));
    check_val("R9 wrap addr", out_addr, 64'h0000_1002_0000_0002);
    // R10: idle cycle drops valid and holds the address
    @(negedge clk);
    check_val("R10 idle valid", {63'd0, out_valid}, 64'd0);
    check_val("R10 hold addr", out_addr, 64'h0000_1002_0000_0002);
    check_val("R10 hold dest", {59'd0, out_dest}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule